// File: doc/BRIEF.md
# Queued Offset Output-Match Waveform Generator

This block drives one output pin through a programmed series of edges without processor help. A small register file holds a queue of relative time offsets. Each entry also carries the pin level to drive when its match fires. The block follows one of two free-running 16-bit timebases. Every match time is the previous match time plus the next offset. The first match is measured from a reference that software selects: the current count, the event time of the last match of the previous sequence, or a time stored in the register file.

Software programs two control words and the queue through a synchronous write port, and reads any word back through a combinational read port. It then issues an init command that sets the starting pin state and picks a sequencing mode:
- single-shot: the queue runs once.
- loop: the queue runs a programmed number of passes.
- continuous: the queue repeats until the block is disabled or re-initialised.

A non-zero pointer field at init arms the block so that an external link pulse starts it. When a single-shot or loop sequence ends, the block writes the final event time back into the register file. A later sequence can use that time as its reference and follow on with no gap.

Top module: `qmatch_gen`

Word 0 (control): bits 3:0 hold the last-entry address, bits 7:4 the reference address, bit 8 the timebase select, bit 9 reference bit B.
Word 1 (sequence): bits 3:0 hold the pointer/link field, bit 4 reference bit C, bits 15:8 the loop count.
Words 2 to 15: queue entries. Word 2 is always offset 1.

## Requirements
- R1: A queue entry drives the pin to its bit 0 (1 high, 0 low). It fires on the first timebase sample that is at or past its target. The target is the previous programmed match time plus the entry's bits 15:1, so the largest step is 0x7FFF counts.
- R2: The reference for the first match is chosen by {word0[9], word1[4]}. 00 selects the current timebase value at init or link. 01 and 11 select the last event time. 10 selects the word addressed by word0[7:4].
- R3: word0[8] chooses the timebase: 0 for tbase_a, 1 for tbase_b. It is sampled only at an init or a link.
- R4: init_cmd 11 drives the pin high and 10 drives it low. 01 leaves the pin unchanged and 00 means no request. Every init and every accepted link raises irq for one cycle. An init replaces any pending match.
- R5: The queue pointer steps from word 2 up to the last-entry address. In continuous mode (seq_mode 1x) it wraps to word 2 and the queue repeats until en is low, after which the pin holds.
- R6: In single-shot mode (seq_mode 00), the block handles the last entry and stops. In the same cycle it writes that match's event time into word 1 and raises irq.
- R7: In loop mode (seq_mode 01), word1[15:8] gives the number of passes. A count of 0 gives 256 passes. After the last pass the block stops with the same write-back and irq.
- R8: A non-zero word1[3:0] at init arms the block without scheduling a match. A link then schedules offset 1 from the selected reference. A link while running restarts at offset 1, measured from the last event time, and does not reload the loop count. A link while stopped is ignored.
- R9: The match test covers a half range. A target outside the window from now to now+0x8000 fires on the next sample. The captured count then becomes the last event time, while the next target is still built from the programmed time.
- R10: Host writes to words 0 and 1 are ignored while the block is armed or running. Queue words are always writable.
- R11: After reset the pin is low, irq is low and every word reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low stops sequencing |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| init_cmd | input | 2 | Init request and starting pin state |
| seq_mode | input | 2 | Sequencing mode, latched at init |
| link_in | input | 1 | Link trigger pulse |
| tbase_a | input | 16 | First free-running timebase |
| tbase_b | input | 16 | Second free-running timebase |
| pin_out | output | 1 | Waveform output pin |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions rely on software placing the last-entry address between word 2 and the top word. They also rely on queue offsets being non-zero, so that each new target lies ahead of the sample that scheduled it, apart from a deliberately stale reference. The stimulus programs only such queues. It writes the control words only while the block is stopped, except for the one test that checks those writes are ignored. It places stored reference times either safely inside the forward window or well behind the counter to provoke an immediate match. Both timebases advance steadily by 1 and by 2 counts per cycle, and all targets on the second one are even, so every event time can be predicted exactly.

// File: rtl/qmatch_gen.sv
`timescale 1ns/1ps
module qmatch_gen #(
  parameter int TW   = 16,
  parameter int NREG = 16,
  parameter int LW   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_addr,
  input  logic [TW-1:0]           wr_data,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [TW-1:0]           rd_data,
  input  logic [1:0]              init_cmd,
  input  logic [1:0]              seq_mode,
  input  logic                    link_in,
  input  logic [TW-1:0]           tbase_a,
  input  logic [TW-1:0]           tbase_b,
  output logic                    pin_out,
  output logic                    irq
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] FIRST = AW'(2);
  localparam int TB_BIT = 2*AW;
  localparam int RB_BIT = 2*AW + 1;
  localparam int RC_BIT = AW;
  localparam logic [TW-1:0] HALF = TW'(1) << (TW-1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN} st_t;

  logic [TW-1:0] regs [NREG];
  st_t           st;
  logic [TW-1:0] match_t, last_evt, now_new, now_run, ref_t, first_t;
  logic [AW-1:0] ptr, nptr, last_a, ref_a;
  logic [LW-1:0] loops;
  logic [1:0]    mode_q;
  logic          tsel, fire, at_end, stop_now, host_ok;

  function automatic logic [TW-1:0] span(input logic [TW-1:0] e);
    return e >> 1;
  endfunction

  assign last_a   = regs[0][AW-1:0];
  assign ref_a    = regs[0][2*AW-1:AW];
  assign nptr     = ptr + AW'(1);
  assign now_new  = regs[0][TB_BIT] ? tbase_b : tbase_a;
  assign now_run  = tsel ? tbase_b : tbase_a;
  assign first_t  = ref_t + span(regs[FIRST]);
  assign fire     = (st == S_RUN) && ((now_run - match_t) < HALF);
  assign at_end   = (ptr == last_a);
  assign stop_now = at_end && (mode_q == 2'b00 || (mode_q == 2'b01 && loops == LW'(1)));
  assign host_ok  = wr_en && (wr_addr >= FIRST || st == S_IDLE);
  assign rd_data  = regs[rd_addr];

  always_comb begin
    case ({regs[0][RB_BIT], regs[1][RC_BIT]})
      2'b00:   ref_t = now_new;
      2'b10:   ref_t = regs[ref_a];
      default: ref_t = last_evt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      st       <= S_IDLE;
      match_t  <= '0;
      last_evt <= '0;
      ptr      <= FIRST;
      loops    <= '0;
      mode_q   <= '0;
      tsel     <= 1'b0;
      pin_out  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (host_ok) regs[wr_addr] <= wr_data;
      if (!en) begin
        st <= S_IDLE;
      end else if (init_cmd != 2'b00) begin
        if (init_cmd[1]) pin_out <= init_cmd[0];
        mode_q <= seq_mode;
        tsel   <= regs[0][TB_BIT];
        loops  <= regs[1][TW-1 -: LW];
        ptr    <= FIRST;
        irq    <= 1'b1;
        if (regs[1][AW-1:0] != '0) begin
          st <= S_ARMED;
        end else begin
          st      <= S_RUN;
          match_t <= first_t;
        end
      end else if (link_in && st != S_IDLE) begin
        tsel    <= regs[0][TB_BIT];
        ptr     <= FIRST;
        irq     <= 1'b1;
        st      <= S_RUN;
        match_t <= (st == S_ARMED) ? first_t : last_evt + span(regs[FIRST]);
      end else if (fire) begin
        pin_out  <= regs[ptr][0];
        last_evt <= now_run;
        if (!at_end) begin
          ptr     <= nptr;
          match_t <= match_t + span(regs[nptr]);
        end else if (stop_now) begin
          st      <= S_IDLE;
          regs[1] <= now_run;
          irq     <= 1'b1;
        end else begin
          ptr     <= FIRST;
          match_t <= match_t + span(regs[FIRST]);
          if (mode_q == 2'b01) loops <= loops - LW'(1);
        end
      end
    end
  end

  p_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en && init_cmd == 2'b00 && !link_in) |=> (pin_out == $past(regs[ptr][0])));

  p_init_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && init_cmd != 2'b00) |=> irq);

  p_ptr_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN) |-> (ptr >= FIRST));

  p_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en && init_cmd == 2'b00 && !link_in && stop_now)
    |=> (regs[1] == $past(now_run) && irq && st == S_IDLE));

  p_loop_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en && init_cmd == 2'b00 && !link_in && at_end && mode_q == 2'b01 && !stop_now)
    |=> (loops == $past(loops) - LW'(1)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && init_cmd == 2'b00) |=> ($stable(pin_out) && !irq));

  p_ctl_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(regs[0]));
endmodule

// File: tb/qmatch_gen_bench.sv
`timescale 1ns/1ps
module qmatch_gen_bench;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wr_en = 1'b0, link_in = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data, now_a = '0, now_b = '0;
  logic [1:0] init_cmd = '0, seq_mode = '0;
  logic pin_out, irq;

  always #2 clk = ~clk;

  qmatch_gen u_qmatch_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .init_cmd(init_cmd), .seq_mode(seq_mode), .link_in(link_in),
    .tbase_a(now_a), .tbase_b(now_b), .pin_out(pin_out), .irq(irq)
  );

  typedef struct { logic [15:0] t; logic lvl; bit onb; int req; } exp_t;
  exp_t sbq[$];
  exp_t e;
  int checks = 0, errors = 0, irq_cnt = 0;
  logic mlvl = 1'b0, prev_pin = 1'b0;
  logic [15:0] qv [14];

  // monitor: pops expected edges, counts irq, advances both timebases
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (pin_out !== prev_pin) begin
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R1: edge to %b at a=%h, expected no edge", pin_out, now_a);
        end else begin
          e = sbq.pop_front();
          if ((e.onb ? now_b : now_a) !== e.t || pin_out !== e.lvl) begin
            errors++;
            $display("FAIL R%0d: edge lvl %b at %h, expected lvl %b at %h",
                     e.req, pin_out, e.onb ? now_b : now_a, e.lvl, e.t);
          end
        end
        prev_pin = pin_out;
      end
    end
    now_a <= now_a + 16'd1;
    now_b <= now_b + 16'd2;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run still busy, expected completion");
    summary();
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic rd_chk(input string r, input logic [AW-1:0] a, input logic [15:0] exp);
    rd_addr = a;
    #0.5;
    chk(r, rd_data, exp);
    tick(1);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic push(input logic [15:0] t, input logic l, input bit onb, input int req);
    if (l !== mlvl) begin
      sbq.push_back('{t, l, onb, req});
      mlvl = l;
    end
  endtask

  // driver: expected edges of a run from a start time
  task automatic plan(input logic [15:0] st, input int n, input int passes,
                      input bit onb, input int req, output logic [15:0] last_t);
    logic [15:0] t = st;
    for (int p = 0; p < passes; p++)
      for (int i = 0; i < n; i++) begin
        t = t + (qv[i] >> 1);
        push(t, qv[i][0], onb, req);
      end
    last_t = t;
  endtask

  task automatic do_init(input logic [1:0] cmd, input logic [1:0] md, input bit onb,
                         input int req, output logic [15:0] t);
    t = onb ? now_b + 16'd2 : now_a + 16'd1;
    if (cmd[1]) push(t, cmd[0], onb, req);
    init_cmd = cmd; seq_mode = md;
    tick(1);
    init_cmd = 2'b00;
  endtask

  task automatic do_link(output logic [15:0] t);
    t = now_a + 16'd1;
    link_in = 1'b1;
    tick(1);
    link_in = 1'b0;
  endtask

  task automatic wait_done(input int lim);
    int k = 0;
    while (sbq.size() != 0 && k < lim) begin tick(1); k++; end
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R%0d: %0d edges missing, expected 0", sbq[0].req, sbq.size());
      sbq.delete();
    end
  endtask

  function automatic logic [15:0] w0(input int last, input int ra, input bit tb, input bit b);
    return 16'(last) | 16'(ra << 4) | (16'(tb) << 8) | (16'(b) << 9);
  endfunction

  function automatic logic [15:0] w1(input int p, input bit c, input int lp);
    return 16'(p) | (16'(c) << 4) | 16'(lp << 8);
  endfunction

  task automatic setup(input logic [15:0] c0, input logic [15:0] c1, input int n);
    for (int i = 0; i < n; i++) wr(AW'(i + 2), qv[i]);
    wr(0, c0);
    wr(1, c1);
  endtask

  initial begin
    logic [15:0] t, tl, t2, rf;
    int i0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    chk("R11 pin", 16'(pin_out), 16'h0);
    chk("R11 irq", 16'(irq), 16'h0);
    rd_chk("R11 word0", 0, 16'h0);
    en = 1'b1;

    // R1 R2 R3 R4 R6: single shot, immediate reference, timebase a, start high
    qv[0] = 16'h0040; qv[1] = 16'h0021; qv[2] = 16'h0060;
    setup(w0(4, 0, 0, 0), w1(0, 0, 0), 3);
    i0 = irq_cnt;
    do_init(2'b11, 2'b00, 0, 4, t);
    plan(t, 3, 1, 0, 1, tl);
    wait_done(2000); tick(3);
    rd_chk("R6 writeback", 1, tl);
    chk("R4 irq count", 16'(irq_cnt - i0), 16'd2);

    // R2: chained from last event time, pin kept
    qv[0] = 16'h0031; qv[1] = 16'h0050;
    setup(w0(3, 0, 0, 0), w1(0, 1, 0), 2);
    do_init(2'b01, 2'b00, 0, 2, t);
    plan(tl, 2, 1, 0, 2, t2);
    wait_done(2000); tick(3);
    rd_chk("R2 chained writeback", 1, t2);

    // R2 R3 R7: stored reference, timebase b, two passes
    rf = now_b + 16'h0100;
    wr(15, rf);
    qv[0] = 16'h0041; qv[1] = 16'h0040;
    setup(w0(3, 15, 1, 1), w1(0, 0, 2), 2);
    i0 = irq_cnt;
    do_init(2'b10, 2'b01, 1, 7, t);
    plan(rf, 2, 2, 1, 3, tl);
    wait_done(2000); tick(3);
    rd_chk("R7 loop writeback", 1, tl);
    chk("R7 irq count", 16'(irq_cnt - i0), 16'd2);

    // R7: loop count 0 gives 256 passes
    qv[0] = 16'h0009; qv[1] = 16'h0008;
    setup(w0(3, 0, 0, 0), w1(0, 0, 0), 2);
    i0 = irq_cnt;
    do_init(2'b01, 2'b01, 0, 7, t);
    plan(t, 2, 256, 0, 7, tl);
    wait_done(5000); tick(3);
    rd_chk("R7 256-pass writeback", 1, tl);
    chk("R7 256-pass irq", 16'(irq_cnt - i0), 16'd2);

    // R5 R10: continuous, locked control words, disable holds pin
    qv[0] = 16'h0021; qv[1] = 16'h0030; qv[2] = 16'h0041;
    setup(w0(4, 0, 0, 0), w1(0, 0, 0), 3);
    i0 = irq_cnt;
    do_init(2'b01, 2'b10, 0, 5, t);
    plan(t, 3, 3, 0, 5, tl);
    wait_done(3000);
    wr(1, 16'hABCD);
    wr(0, 16'h1234);
    en = 1'b0;
    tick(60);
    chk("R5 pin held", 16'(pin_out), 16'(mlvl));
    chk("R5 irq count", 16'(irq_cnt - i0), 16'd1);
    en = 1'b1;
    rd_chk("R10 word1", 1, 16'h0);
    rd_chk("R10 word0", 0, w0(4, 0, 0, 0));

    // R8: linked start, restart while running, ignored when stopped
    qv[0] = 16'h0040; qv[1] = 16'h0061; qv[2] = 16'h0080;
    setup(w0(4, 0, 0, 0), w1(1, 0, 0), 3);
    i0 = irq_cnt;
    do_init(2'b11, 2'b00, 0, 8, t);
    tick(50);
    chk("R8 armed irq", 16'(irq_cnt - i0), 16'd1);
    do_link(t);
    plan(t, 1, 1, 0, 8, tl);
    wait_done(500);
    do_link(t2);
    plan(tl, 3, 1, 0, 8, t2);
    wait_done(1000); tick(3);
    rd_chk("R8 restart writeback", 1, t2);
    chk("R8 irq count", 16'(irq_cnt - i0), 16'd4);
    do_link(t);
    tick(30);
    chk("R8 stopped link irq", 16'(irq_cnt - i0), 16'd4);
    rd_chk("R8 stopped link word1", 1, t2);

    // R9: stale reference fires at once, next target from programmed time
    rf = now_a - 16'h0100;
    wr(15, rf);
    qv[0] = 16'h0201; qv[1] = 16'h0400;
    setup(w0(3, 15, 0, 1), w1(0, 0, 0), 2);
    do_init(2'b01, 2'b00, 0, 9, t);
    push(t + 16'd1, 1'b1, 0, 9);
    push(rf + 16'h0100 + 16'h0200, 1'b0, 0, 9);
    wait_done(2000); tick(3);
    rd_chk("R9 writeback", 1, rf + 16'h0300);

    // R9: immediate final match writes back the captured count
    rf = now_a - 16'h0100;
    wr(15, rf);
    qv[0] = 16'h0201;
    setup(w0(2, 15, 0, 1), w1(0, 0, 0), 1);
    do_init(2'b01, 2'b00, 0, 9, t);
    push(t + 16'd1, 1'b1, 0, 9);
    wait_done(100); tick(3);
    rd_chk("R9 captured time", 1, t + 16'd1);

    // R4: second init cancels pending match
    qv[0] = 16'h0801;
    setup(w0(2, 0, 0, 0), w1(0, 0, 0), 1);
    i0 = irq_cnt;
    do_init(2'b10, 2'b00, 0, 4, t);
    tick(64);
    do_init(2'b10, 2'b00, 0, 4, t2);
    push(t2 + 16'h0400, 1'b1, 0, 4);
    wait_done(3000); tick(3);
    chk("R4 cancel irq", 16'(irq_cnt - i0), 16'd3);

    tick(5);
    summary();
    $finish;
  end
endmodule